// File: doc/BRIEF.md
# Serial Command Stream to Register Bus Bridge

This block sits between a byte-oriented serial receiver and a simple 8-bit register bus. It reads a host command stream one byte at a time and turns each framed packet into a burst of register-bus writes or reads. Read results go back to the host through a byte transmitter that has a valid/ready handshake.

Each packet has a fixed layout: an opcode byte, then a length byte, then a 32-bit start address sent most significant byte first. A write packet then carries `length` data bytes, and each one becomes one bus write. A read packet carries no data: the bridge issues `length` bus reads and sends each returned byte back to the host. The address steps up by one per byte. A wide register is therefore moved as a burst, and its first byte lands at the lowest address.

The register bank behind the bus returns read data one clock after the address is presented. The bridge handles one packet at a time and does not buffer input.

Top module: `serial_csr_bridge`

## Requirements
- R1: In the idle state, byte 0x01 starts a write packet and byte 0x02 starts a read packet. Any other byte received while idle is dropped. It causes no bus access and no transmitted byte, and the next byte is again treated as an opcode.
- R2: After the opcode, the next byte is the burst length. The four bytes after that form the start address, most significant byte first.
- R3: In a write packet, each data byte accepted on `rx_valid` produces exactly one `csr_we` pulse, one clock after the byte is accepted. That pulse carries `csr_wdata` equal to the byte. Back-to-back bytes give back-to-back pulses.
- R4: Within a burst, byte i is accessed at start address + i. The carry propagates across the full 32-bit address.
- R5: In a read packet, each returned byte is presented on `tx_byte` with `tx_valid`. The byte stays stable until `tx_ready` is seen. The next bus read is issued only after that handshake.
- R6: The bridge samples `csr_rdata` one clock after it presents the read address. Byte i of a read burst therefore equals the register content at start address + i.
- R7: A burst length of 0 completes the packet with no bus access and no transmitted byte.
- R8: After the last byte of a burst, the bridge is idle, so the very next byte is taken as an opcode.
- R9: A synchronous reset discards any partly received packet and forces the idle state, with `csr_we` and `tx_valid` low.
- R10: Bytes that arrive on `rx_valid` while a read burst is in progress are ignored. They have no effect on the returned bytes or on later packets.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rx_byte | input | 8 | Received byte |
| rx_valid | input | 1 | One-cycle strobe marking `rx_byte` valid |
| tx_byte | output | 8 | Byte to transmit |
| tx_valid | output | 1 | `tx_byte` holds a byte to send |
| tx_ready | input | 1 | Transmitter accepts `tx_byte` this cycle |
| csr_addr | output | 32 | Register bus address |
| csr_we | output | 1 | Single-cycle write strobe |
| csr_wdata | output | 8 | Register bus write data |
| csr_rdata | input | 8 | Register bus read data, valid one clock after the address |

## Verification
A write byte accepted at one rising edge must show `csr_we`, its address and its data at the falling edge right after that rising edge. At every other falling edge during a write packet, `csr_we` must be low. For reads, the first byte is due two edges after the last address byte is accepted: one edge presents the address and one captures the bank output. The bench still polls `tx_valid` at each falling edge, with a bound on how long it waits, and checks that `csr_we` stays low while it polls. While `tx_ready` is held low, the bench checks the held byte every cycle. After each burst it watches a few idle cycles for any stray access or byte.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEN,
        ST_ADDR,
        ST_WDATA,
        ST_RISSUE,
        ST_RWAIT,
        ST_RSEND
    } sbr_state_e;

    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h02;
endpackage

// File: rtl/sbr_addr_reg.sv
module sbr_addr_reg #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              shift_en,
    input  logic [BYTE_W-1:0] shift_byte,
    input  logic              inc_en,
    output logic [ADDR_W-1:0] addr
);
    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (shift_en)
            addr_d = {addr_q[ADDR_W-BYTE_W-1:0], shift_byte};
        else if (inc_en)
            addr_d = addr_q + ADDR_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) addr_q <= '0;
        else     addr_q <= addr_d;
    end

    assign addr = addr_q;

    // R2
    addr_shift_chk: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> addr[BYTE_W-1:0] == $past(shift_byte));
endmodule

// File: rtl/sbr_tx_slot.sv
module sbr_tx_slot #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [BYTE_W-1:0] load_byte,
    input  logic              tx_ready,
    output logic              tx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              sent
);
    typedef struct packed {
        logic              valid;
        logic [BYTE_W-1:0] data;
    } slot_t;

    slot_t slot_d, slot_q;

    always_comb begin
        slot_d = slot_q;
        if (slot_q.valid && tx_ready)
            slot_d.valid = 1'b0;
        if (load) begin
            slot_d.valid = 1'b1;
            slot_d.data  = load_byte;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) slot_q <= '0;
        else     slot_q <= slot_d;
    end

    assign tx_valid = slot_q.valid;
    assign tx_byte  = slot_q.data;
    assign sent     = slot_q.valid & tx_ready;

    // R5
    tx_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_byte)));
endmodule

// File: rtl/serial_csr_bridge.sv
module serial_csr_bridge #(
    parameter int ADDR_W = 32,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [BYTE_W-1:0] rx_byte,
    input  logic              rx_valid,
    output logic [BYTE_W-1:0] tx_byte,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [ADDR_W-1:0] csr_addr,
    output logic              csr_we,
    output logic [BYTE_W-1:0] csr_wdata,
    input  logic [BYTE_W-1:0] csr_rdata
);
    import sbr_pkg::*;

    localparam int ADDR_BYTES = ADDR_W / BYTE_W;
    localparam int CNT_W      = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

    typedef struct packed {
        sbr_state_e        st;
        logic              rd;
        logic [BYTE_W-1:0] rem;
        logic [CNT_W-1:0]  acnt;
        logic              we;
        logic [BYTE_W-1:0] wdata;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic addr_shift, addr_inc, tx_load, tx_sent;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.we   = 1'b0;
        addr_shift = 1'b0;
        addr_inc   = ctl_q.we;
        tx_load    = 1'b0;
        unique case (ctl_q.st)
            ST_IDLE: if (rx_valid) begin
                if (rx_byte == OP_WRITE) begin
                    ctl_d.st = ST_LEN;
                    ctl_d.rd = 1'b0;
                end else if (rx_byte == OP_READ) begin
                    ctl_d.st = ST_LEN;
                    ctl_d.rd = 1'b1;
                end
            end
            ST_LEN: if (rx_valid) begin
                ctl_d.rem  = rx_byte;
                ctl_d.acnt = '0;
                ctl_d.st   = ST_ADDR;
            end
            ST_ADDR: if (rx_valid) begin
                addr_shift = 1'b1;
                ctl_d.acnt = ctl_q.acnt + CNT_W'(1);
                if (ctl_q.acnt == CNT_W'(ADDR_BYTES - 1)) begin
                    if (ctl_q.rem == '0) ctl_d.st = ST_IDLE;
                    else if (ctl_q.rd)   ctl_d.st = ST_RISSUE;
                    else                 ctl_d.st = ST_WDATA;
                end
            end
            ST_WDATA: if (rx_valid) begin
                ctl_d.we    = 1'b1;
                ctl_d.wdata = rx_byte;
                ctl_d.rem   = ctl_q.rem - BYTE_W'(1);
                if (ctl_q.rem == BYTE_W'(1)) ctl_d.st = ST_IDLE;
            end
            ST_RISSUE: ctl_d.st = ST_RWAIT;
            ST_RWAIT: begin
                tx_load   = 1'b1;
                addr_inc  = 1'b1;
                ctl_d.rem = ctl_q.rem - BYTE_W'(1);
                ctl_d.st  = ST_RSEND;
            end
            ST_RSEND: if (tx_sent) begin
                ctl_d.st = (ctl_q.rem == '0) ? ST_IDLE : ST_RISSUE;
            end
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q    <= '0;
            ctl_q.st <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    sbr_addr_reg #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_addr (
        .clk        (clk),
        .rst        (rst),
        .shift_en   (addr_shift),
        .shift_byte (rx_byte),
        .inc_en     (addr_inc),
        .addr       (csr_addr)
    );

    sbr_tx_slot #(.BYTE_W(BYTE_W)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .load      (tx_load),
        .load_byte (csr_rdata),
        .tx_ready  (tx_ready),
        .tx_valid  (tx_valid),
        .tx_byte   (tx_byte),
        .sent      (tx_sent)
    );

    assign csr_we    = ctl_q.we;
    assign csr_wdata = ctl_q.wdata;

    // R3
    we_follows_rx_chk: assert property (@(posedge clk) disable iff (rst)
        csr_we |-> $past(rx_valid));

    // R4
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        csr_we |=> csr_addr == $past(csr_addr) + ADDR_W'(1));

    // R10
    no_write_in_read_chk: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !csr_we);

    // R9
    reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!tx_valid && !csr_we));
endmodule

// File: tb/serial_csr_bridge_tb.sv
module serial_csr_bridge_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rx_byte = '0;
    logic        rx_valid = 1'b0;
    logic [7:0]  tx_byte;
    logic        tx_valid;
    logic        tx_ready = 1'b0;
    logic [31:0] csr_addr;
    logic        csr_we;
    logic [7:0]  csr_wdata;
    logic [7:0]  csr_rdata = '0;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [7:0] bank  [256];
    logic [7:0] model [256];

    always #4 clk = ~clk;

    serial_csr_bridge u_dut (
        .clk(clk), .rst(rst), .rx_byte(rx_byte), .rx_valid(rx_valid),
        .tx_byte(tx_byte), .tx_valid(tx_valid), .tx_ready(tx_ready),
        .csr_addr(csr_addr), .csr_we(csr_we), .csr_wdata(csr_wdata),
        .csr_rdata(csr_rdata)
    );

    // register bank with one clock of read latency
    always @(posedge clk) begin
        csr_rdata <= bank[csr_addr[7:0]];
        if (csr_we) bank[csr_addr[7:0]] <= csr_wdata;
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL watchdog: act=%0d exp=<100000 cycles", cyc);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    // drive one byte at a falling edge; check at the next falling edge
    task automatic send(input logic [7:0] b, input bit exp_we,
                        input logic [31:0] ea, input string req);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
        chk(csr_we == exp_we, req, "csr_we", csr_we, exp_we);
        if (exp_we) begin
            chk(csr_addr == ea, req, "csr_addr", csr_addr, ea);
            chk(csr_wdata == b, req, "csr_wdata", csr_wdata, b);
        end
        chk(tx_valid == 1'b0, req, "tx_valid", tx_valid, 0);
    endtask

    task automatic idle(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(csr_we == 1'b0 && tx_valid == 1'b0, req, "quiet",
                {csr_we, tx_valid}, 0);
        end
    endtask

    task automatic header(input logic [7:0] op, input logic [7:0] len,
                          input logic [31:0] a, input string req);
        send(op, 0, 0, req);
        send(len, 0, 0, req);
        for (int k = 3; k >= 0; k--) send(a[8*k +: 8], 0, 0, req);
    endtask

    task automatic wr_pkt(input logic [31:0] a, input int len,
                          input logic [7:0] seed, input bit gap);
        header(8'h01, 8'(len), a, "R2");
        for (int i = 0; i < len; i++) begin
            logic [7:0] d;
            logic [31:0] ea;
            d  = seed + 8'(i * 7);
            ea = a + 32'(i);
            model[ea[7:0]] = d;
            send(d, 1, ea, "R3/R4");
            if (gap) idle(1, "R3");
        end
    endtask

    task automatic rd_pkt(input logic [31:0] a, input int len,
                          input int stall, input bit junk);
        header(8'h02, 8'(len), a, "R2");
        for (int i = 0; i < len; i++) begin
            logic [31:0] ea;
            int w;
            ea = a + 32'(i);
            w = 0;
            while (!tx_valid && w < 20) begin
                chk(csr_we == 1'b0, "R10", "csr_we in read", csr_we, 0);
                @(negedge clk);
                w++;
            end
            chk(tx_valid == 1'b1, "R5", "tx_valid", tx_valid, 1);
            chk(tx_byte == model[ea[7:0]], "R6", "tx_byte", tx_byte, model[ea[7:0]]);
            for (int s = 0; s < stall; s++) begin
                rx_valid = junk;
                rx_byte  = 8'h01;
                @(negedge clk);
                rx_valid = 1'b0;
                chk(tx_valid == 1'b1 && tx_byte == model[ea[7:0]], "R5",
                    "held byte", tx_byte, model[ea[7:0]]);
            end
            tx_ready = 1'b1;
            @(negedge clk);
            tx_ready = 1'b0;
        end
        idle(3, "R8");
    endtask

    initial begin
        for (int i = 0; i < 256; i++) begin
            bank[i]  = 8'(i) ^ 8'hA5;
            model[i] = 8'(i) ^ 8'hA5;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9 reset state
        chk(csr_we == 0 && tx_valid == 0, "R9", "reset outputs", {csr_we, tx_valid}, 0);

        // R1: junk opcodes ignored
        send(8'h00, 0, 0, "R1");
        send(8'h03, 0, 0, "R1");
        send(8'hFF, 0, 0, "R1");
        send(8'h7E, 0, 0, "R1");
        idle(2, "R1");

        // R3 back-to-back, R4 carry across bytes
        wr_pkt(32'h1234_56FE, 4, 8'h11, 0);
        idle(3, "R8");
        // R3 gapped bytes, immediately followed by another packet (R8)
        wr_pkt(32'h0000_0040, 3, 8'h80, 1);
        wr_pkt(32'hFFFF_FFFF, 2, 8'h33, 0);

        // R5/R6 reads, no stall then stalled with junk input (R10)
        rd_pkt(32'h1234_56FE, 4, 0, 0);
        rd_pkt(32'h0000_0040, 3, 2, 1);
        rd_pkt(32'h0000_0090, 2, 1, 0);

        // R7 zero length
        header(8'h01, 8'h00, 32'h0000_0010, "R7");
        idle(4, "R7");
        header(8'h02, 8'h00, 32'h0000_0010, "R7");
        idle(4, "R7");
        wr_pkt(32'h0000_0010, 1, 8'h5C, 0);

        // R9 reset mid-packet discards partial header
        send(8'h01, 0, 0, "R9");
        send(8'h03, 0, 0, "R9");
        send(8'h00, 0, 0, "R9");
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        chk(csr_we == 0 && tx_valid == 0, "R9", "after reset", {csr_we, tx_valid}, 0);
        wr_pkt(32'h0000_00C0, 2, 8'h21, 0);
        rd_pkt(32'h0000_00C0, 2, 0, 0);
        rd_pkt(32'h0000_0010, 1, 0, 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule